// File: doc/BRIEF.md
# Translation Fault Checker with Superpage Support

This block sits next to a translation lookaside buffer and judges every hit. From the cached page table entry, the page size recorded with that entry, the kind of access and the processor state, it decides whether the access must raise a page fault. When it does, it also produces a cause code that tells fetch, load and store faults apart. The verdict is registered, so it appears one clock after the lookup that produced it. The pipeline uses it to turn the hit into a trap.

The entry layout is fixed. Bits 0 to 7 hold the flags valid (V), readable (R), writable (W), executable (X), user (U), global (G), accessed (A) and dirty (D), from bit 0 upward. Bits 8 and 9 are ignored. The physical page number starts at bit 10. A parameter selects the two-level scheme or the three-level scheme:

- The two-level scheme uses a 32-bit entry, a 22-bit page number and 10-bit segments.
- The three-level scheme uses a 64-bit entry, a 44-bit page number and 9-bit segments.

The checker covers superpages. It faults a large page whose physical base is not aligned to its own size. The accessed and dirty flags are never updated in hardware, so the checker faults whenever software would need to set one of them.

Top module: `xfc_top`

## Requirements
- R1: While `rst_n` is low, `fault` is 0 and `cause` is 00.
- R2: The verdict for the inputs sampled at a rising clock edge appears on `fault`/`cause` after that edge. `fault` is 1 only if both `hit` and `req` were 1.
- R3: No fault is raised when `xlat_en` is 0 or `priv` is 10 or 11 (machine mode). Only `priv` 00 (user) and 01 (supervisor) translate.
- R4: An entry with V (bit 0) clear, or with W (bit 2) set while R (bit 1) is clear, faults any access.
- R5: Any access faults when A (bit 6) is clear.
- R6: A store faults when D (bit 7) is clear. A load with D clear and every other condition met does not fault.
- R7: `kind` 00 is a fetch and needs X (bit 3). `kind` 10 or 11 is a store and needs W (bit 2).
- R8: `kind` 01 is a load. It needs R, or X when `mxr` is 1.
- R9: A user access (`priv` 00) faults unless U (bit 4) is set.
- R10: A supervisor access (`priv` 01) to a page with U set behaves as follows:
  - a fetch always faults;
  - a load or store faults unless `sum` is 1.
- R11: `page_type` 00 is a base page and is never checked for alignment. `page_type` 01 is a megapage and faults when the lowest page number segment is nonzero. That segment is entry bits 18:10 for three levels and 19:10 for two levels.
- R12: `page_type` 11 behaves as follows:
  - with three levels it is a gigapage, and it faults when entry bits 27:10 are nonzero;
  - with two levels it always faults.
  `page_type` 10 always faults.
- R13: `cause` is 01 for a fetch fault, 10 for a load fault and 11 for a store fault. It is 00 whenever `fault` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit | input | 1 | The lookup matched an entry |
| req | input | 1 | An access is requested this cycle |
| kind | input | 2 | 00 fetch, 01 load, 10/11 store |
| priv | input | 2 | 00 user, 01 supervisor, 10/11 untranslated |
| xlat_en | input | 1 | Address translation is switched on |
| sum | input | 1 | Lets supervisor loads and stores reach user pages |
| mxr | input | 1 | Lets loads read execute-only pages |
| page_type | input | 2 | 00 base page, 01 megapage, 11 gigapage |
| entry | input | PTE_W | Cached page table entry (32 or 64 bits) |
| fault | output | 1 | Registered page-fault verdict |
| cause | output | 2 | Registered fault cause |

## Verification
The bench drives a three-level and a two-level instance with the same stimulus. The key probe is a megapage whose page number has only bit 9 set: it is aligned with 9-bit segments but misaligned with 10-bit segments. An alignment check sized with the wrong segment width would therefore agree on one instance and fail on the other.

Other probes target the permission rules:

- An execute-only page loaded with and without `mxr`. A design that tested only R would fault even when `mxr` is set.
- Supervisor fetches and loads to user pages with `sum` high. A design that let `sum` cover fetches would miss the fault.
- A load with D clear, which must pass. A design that applied the dirty rule to every access would fault it.

Further probes check the gating. A faulting entry presented with no hit, no request, translation off or machine mode must stay silent. The gigapage type on the two-level instance must always fault.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
  localparam int FLAG_W  = 8;
  localparam int PPN_LSB = 10;

  localparam logic [1:0] KIND_FETCH = 2'b00;
  localparam logic [1:0] KIND_LOAD  = 2'b01;

  localparam logic [1:0] PRIV_USER  = 2'b00;
  localparam logic [1:0] PRIV_SUPER = 2'b01;

  localparam logic [1:0] PT_BASE = 2'b00;
  localparam logic [1:0] PT_MEGA = 2'b01;
  localparam logic [1:0] PT_RSVD = 2'b10;
  localparam logic [1:0] PT_GIGA = 2'b11;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_FETCH = 2'b01,
    CAUSE_LOAD  = 2'b10,
    CAUSE_STORE = 2'b11
  } cause_e;

  typedef struct packed {
    logic d;
    logic a;
    logic g;
    logic u;
    logic x;
    logic w;
    logic r;
    logic v;
  } flags_t;

  function automatic int seg_width(int levels);
    return (levels == 3) ? 9 : 10;
  endfunction

  function automatic int ppn_width(int levels);
    return (levels == 3) ? 44 : 22;
  endfunction
endpackage

// File: rtl/xfc_legal_check.sv
module xfc_legal_check
  import xfc_pkg::*;
(
  input  logic       v,
  input  logic       r,
  input  logic       w,
  input  logic       x,
  input  logic       a,
  input  logic       d,
  input  logic [1:0] kind,
  input  logic       mxr,
  output logic       legal_fault
);
  logic is_fetch, is_load, is_store;
  logic bad_entry, bad_track, bad_right;

  always_comb begin
    is_fetch  = (kind == KIND_FETCH);
    is_load   = (kind == KIND_LOAD);
    is_store  = kind[1];
    bad_entry = ~v | (w & ~r);
    bad_track = ~a | (is_store & ~d);
    bad_right = (is_fetch & ~x) |
                (is_load  & ~(r | (mxr & x))) |
                (is_store & ~w);
    legal_fault = bad_entry | bad_track | bad_right;
  end
endmodule

// File: rtl/xfc_priv_check.sv
module xfc_priv_check
  import xfc_pkg::*;
(
  input  logic       u,
  input  logic [1:0] kind,
  input  logic [1:0] priv,
  input  logic       sum,
  output logic       priv_fault
);
  logic user_mode, super_mode, is_fetch;

  always_comb begin
    user_mode  = (priv == PRIV_USER);
    super_mode = (priv == PRIV_SUPER);
    is_fetch   = (kind == KIND_FETCH);
    priv_fault = (user_mode & ~u) |
                 (super_mode & u & (is_fetch | ~sum));
  end
endmodule

// File: rtl/xfc_align_check.sv
module xfc_align_check
  import xfc_pkg::*;
#(
  parameter int LEVELS = 3,
  localparam int SEG_W = seg_width(LEVELS),
  localparam int ALIGN_W = (LEVELS - 1) * SEG_W
) (
  input  logic [ALIGN_W-1:0] ppn_low,
  input  logic [1:0]         page_type,
  output logic               align_fault
);
  logic mega_bad;

  assign mega_bad = |ppn_low[SEG_W-1:0];

  generate
    if (LEVELS == 3) begin : g_three
      logic giga_bad;
      assign giga_bad = |ppn_low[2*SEG_W-1:0];
      always_comb begin
        unique case (page_type)
          PT_BASE: align_fault = 1'b0;
          PT_MEGA: align_fault = mega_bad;
          PT_GIGA: align_fault = giga_bad;
          default: align_fault = 1'b1;
        endcase
      end
    end else begin : g_two
      always_comb begin
        unique case (page_type)
          PT_BASE: align_fault = 1'b0;
          PT_MEGA: align_fault = mega_bad;
          PT_RSVD: align_fault = 1'b1;
          default: align_fault = 1'b1;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/xfc_out_reg.sv
module xfc_out_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fault_d,
  input  logic [1:0] cause_d,
  output logic       fault_q,
  output logic [1:0] cause_q
);
  logic       fault_nx;
  logic [1:0] cause_nx;

  always_comb begin
    fault_nx = fault_d;
    cause_nx = fault_d ? cause_d : 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      cause_q <= 2'b00;
    end else begin
      fault_q <= fault_nx;
      cause_q <= cause_nx;
    end
  end
endmodule

// File: rtl/xfc_top.sv
module xfc_top
  import xfc_pkg::*;
#(
  parameter int LEVELS = 3,
  localparam int PTE_W = (LEVELS == 3) ? 64 : 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             req,
  input  logic [1:0]       kind,
  input  logic [1:0]       priv,
  input  logic             xlat_en,
  input  logic             sum,
  input  logic             mxr,
  input  logic [1:0]       page_type,
  input  logic [PTE_W-1:0] entry,
  output logic             fault,
  output logic [1:0]       cause
);
  localparam int SEG_W   = seg_width(LEVELS);
  localparam int ALIGN_W = (LEVELS - 1) * SEG_W;

  flags_t              flags;
  logic [ALIGN_W-1:0]  ppn_low;
  logic                legal_fault, priv_fault, align_fault;
  logic                checking, fault_d;
  logic [1:0]          cause_d;
  logic                unused_bits;

  assign flags   = flags_t'(entry[FLAG_W-1:0]);
  assign ppn_low = entry[PPN_LSB +: ALIGN_W];
  assign unused_bits = ^{entry[PTE_W-1:PPN_LSB+ALIGN_W], entry[PPN_LSB-1:FLAG_W], flags.g};

  xfc_legal_check u_legal (
    .v(flags.v), .r(flags.r), .w(flags.w), .x(flags.x),
    .a(flags.a), .d(flags.d),
    .kind(kind), .mxr(mxr),
    .legal_fault(legal_fault)
  );

  xfc_priv_check u_priv (
    .u(flags.u), .kind(kind), .priv(priv), .sum(sum),
    .priv_fault(priv_fault)
  );

  xfc_align_check #(.LEVELS(LEVELS)) u_align (
    .ppn_low(ppn_low), .page_type(page_type),
    .align_fault(align_fault)
  );

  always_comb begin
    checking = hit & req & xlat_en & ~priv[1];
    fault_d  = checking & (legal_fault | priv_fault | align_fault);
    if (kind == KIND_FETCH)     cause_d = CAUSE_FETCH;
    else if (kind == KIND_LOAD) cause_d = CAUSE_LOAD;
    else                        cause_d = CAUSE_STORE;
  end

  xfc_out_reg u_out (
    .clk(clk), .rst_n(rst_n),
    .fault_d(fault_d), .cause_d(cause_d),
    .fault_q(fault), .cause_q(cause)
  );
endmodule

// File: rtl/xfc_checker.sv
module xfc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       hit,
  input logic       req,
  input logic [1:0] kind,
  input logic [1:0] priv,
  input logic       xlat_en,
  input logic       v_bit,
  input logic       a_bit,
  input logic       d_bit,
  input logic       fault,
  input logic [1:0] cause
);
  logic armed;
  logic live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assign live = hit & req & xlat_en & ((priv == 2'b00) | (priv == 2'b01));

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (!fault && cause == 2'b00)); // R1

  AST_NEEDS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(!(hit && req))) |-> !fault); // R2

  AST_UNTRANSLATED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(!xlat_en || priv[1])) |-> !fault); // R3

  AST_INVALID_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(live && !v_bit)) |-> fault); // R4

  AST_ACCESSED_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(live && !a_bit)) |-> fault); // R5

  AST_CLEAN_STORE_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(live && kind[1] && !d_bit)) |-> fault); // R6

  AST_NO_CAUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |-> cause == 2'b00); // R13

  AST_CAUSE_MATCHES_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && fault) |-> cause == (($past(kind) == 2'b00) ? 2'b01 :
                                   (($past(kind) == 2'b01) ? 2'b10 : 2'b11))); // R13
endmodule

bind xfc_top xfc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .hit(hit), .req(req), .kind(kind),
  .priv(priv), .xlat_en(xlat_en),
  .v_bit(entry[0]), .a_bit(entry[6]), .d_bit(entry[7]),
  .fault(fault), .cause(cause)
);

// File: tb/xfc_top_test.sv
`timescale 1ns/1ps
module xfc_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hit = 1'b0, req = 1'b0;
  logic [1:0]  kind = 2'b00, priv = 2'b01;
  logic        xlat_en = 1'b0, sum = 1'b0, mxr = 1'b0;
  logic [1:0]  page_type = 2'b00;
  logic [63:0] entry = 64'd0;
  logic        fault3, fault2;
  logic [1:0]  cause3, cause2;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [2:0] e3;
    logic [2:0] e2;
    string      tag;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  xfc_top #(.LEVELS(3)) uut (
    .clk(clk), .rst_n(rst_n), .hit(hit), .req(req), .kind(kind), .priv(priv),
    .xlat_en(xlat_en), .sum(sum), .mxr(mxr), .page_type(page_type),
    .entry(entry), .fault(fault3), .cause(cause3)
  );

  xfc_top #(.LEVELS(2)) uut_l2 (
    .clk(clk), .rst_n(rst_n), .hit(hit), .req(req), .kind(kind), .priv(priv),
    .xlat_en(xlat_en), .sum(sum), .mxr(mxr), .page_type(page_type),
    .entry(entry[31:0]), .fault(fault2), .cause(cause2)
  );

  function automatic logic [2:0] model(int lv, logic h, logic r, logic [1:0] k,
                                       logic [1:0] p, logic en, logic s, logic m,
                                       logic [1:0] pt, logic [63:0] ent_in);
    logic [63:0] ent, ppn;
    int seg;
    logic f;
    logic [1:0] c;
    ent = (lv == 2) ? (ent_in & 64'hFFFF_FFFF) : ent_in;
    ppn = (ent >> 10) & 64'h0000_0FFF_FFFF_FFFF;
    seg = (lv == 3) ? 9 : 10;
    f = 1'b0;
    if (!ent[0] || (ent[2] && !ent[1])) f = 1'b1;
    if (!ent[6]) f = 1'b1;
    if (k[1] && !ent[7]) f = 1'b1;
    if (k == 2'b00 && !ent[3]) f = 1'b1;
    if (k == 2'b01 && !(ent[1] || (m && ent[3]))) f = 1'b1;
    if (k[1] && !ent[2]) f = 1'b1;
    if (p == 2'b00 && !ent[4]) f = 1'b1;
    if (p == 2'b01 && ent[4] && (k == 2'b00 || !s)) f = 1'b1;
    if (pt == 2'b10) f = 1'b1;
    if (pt == 2'b01 && (ppn & ((64'd1 << seg) - 1)) != 0) f = 1'b1;
    if (pt == 2'b11) begin
      if (lv == 2) f = 1'b1;
      else if ((ppn & ((64'd1 << (2 * seg)) - 1)) != 0) f = 1'b1;
    end
    if (!(h && r && en && !p[1])) f = 1'b0;
    c = !f ? 2'b00 : (k == 2'b00 ? 2'b01 : (k == 2'b01 ? 2'b10 : 2'b11));
    return {f, c};
  endfunction

  function automatic logic [63:0] mk(logic [7:0] fl, logic [63:0] ppn);
    return (ppn << 10) | {56'd0, fl};
  endfunction

  task automatic check(string tag, string unit, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s]: fault/cause actual=%b expected=%b", tag, unit, act, exp);
    end
  endtask

  task automatic apply(string tag, logic h, logic r, logic [1:0] k, logic [1:0] p,
                       logic en, logic s, logic m, logic [1:0] pt, logic [63:0] ent);
    item_t it;
    @(negedge clk);
    hit = h; req = r; kind = k; priv = p; xlat_en = en; sum = s; mxr = m;
    page_type = pt; entry = ent;
    it.e3 = model(3, h, r, k, p, en, s, m, pt, ent);
    it.e2 = model(2, h, r, k, p, en, s, m, pt, ent);
    it.tag = tag;
    sb.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && sb.size() > 0) begin
        it = sb.pop_front();
        check(it.tag, "3-level", {fault3, cause3}, it.e3);
        check(it.tag, "2-level", {fault2, cause2}, it.e2);
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  localparam logic [1:0] F = 2'b00, L = 2'b01, ST = 2'b10, ST2 = 2'b11;
  localparam logic [1:0] PU = 2'b00, PS = 2'b01, PM = 2'b11;

  initial begin : driver
    // R1: reset holds outputs quiet even with a faulting lookup present
    hit = 1'b1; req = 1'b1; xlat_en = 1'b1; kind = L; priv = PS; entry = 64'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", "3-level", {fault3, cause3}, 3'b000);
    check("R1 reset", "2-level", {fault2, cause2}, 3'b000);
    rst_n = 1'b1;

    apply("R2 no hit",          0, 1, L, PS, 1, 0, 0, 2'b00, mk(8'h00, 0));
    apply("R2 no request",      1, 0, L, PS, 1, 0, 0, 2'b00, mk(8'h00, 0));
    apply("R2 clean load",      1, 1, L, PS, 1, 0, 0, 2'b00, mk(8'hCF, 5));
    apply("R3 translation off", 1, 1, L, PS, 0, 0, 0, 2'b00, mk(8'h00, 0));
    apply("R3 machine mode",    1, 1, L, PM, 1, 0, 0, 2'b00, mk(8'h00, 0));
    apply("R3 mode 10",         1, 1, ST, 2'b10, 1, 0, 0, 2'b00, mk(8'h00, 0));
    apply("R4 valid clear",     1, 1, L, PS, 1, 0, 0, 2'b00, mk(8'hCE, 0));
    apply("R4 write-only",      1, 1, L, PS, 1, 0, 0, 2'b00, mk(8'hCD, 0));
    apply("R5 accessed clear",  1, 1, F, PS, 1, 0, 0, 2'b00, mk(8'h8F, 0));
    apply("R6 store dirty clr", 1, 1, ST, PS, 1, 0, 0, 2'b00, mk(8'h4F, 0));
    apply("R6 load dirty clr",  1, 1, L, PS, 1, 0, 0, 2'b00, mk(8'h4F, 0));
    apply("R7 fetch no X",      1, 1, F, PS, 1, 0, 0, 2'b00, mk(8'hC7, 0));
    apply("R7 store no W",      1, 1, ST, PS, 1, 0, 0, 2'b00, mk(8'hCB, 0));
    apply("R7 fetch with X",    1, 1, F, PS, 1, 0, 0, 2'b00, mk(8'hC9, 0));
    apply("R8 exec-only load",  1, 1, L, PS, 1, 0, 0, 2'b00, mk(8'hC9, 0));
    apply("R8 exec-only mxr",   1, 1, L, PS, 1, 0, 1, 2'b00, mk(8'hC9, 0));
    apply("R9 user super page", 1, 1, L, PU, 1, 0, 0, 2'b00, mk(8'hCF, 0));
    apply("R9 user user page",  1, 1, L, PU, 1, 0, 0, 2'b00, mk(8'hDF, 0));
    apply("R10 fetch sum set",  1, 1, F, PS, 1, 1, 0, 2'b00, mk(8'hDF, 0));
    apply("R10 load sum clr",   1, 1, L, PS, 1, 0, 0, 2'b00, mk(8'hDF, 0));
    apply("R10 load sum set",   1, 1, L, PS, 1, 1, 0, 2'b00, mk(8'hDF, 0));
    apply("R10 store sum set",  1, 1, ST, PS, 1, 1, 0, 2'b00, mk(8'hDF, 0));
    apply("R11 mega bit0",      1, 1, L, PS, 1, 0, 0, 2'b01, mk(8'hCF, 64'd1));
    apply("R11 mega bit9",      1, 1, L, PS, 1, 0, 0, 2'b01, mk(8'hCF, 64'd1 << 9));
    apply("R11 mega bit10",     1, 1, L, PS, 1, 0, 0, 2'b01, mk(8'hCF, 64'd1 << 10));
    apply("R11 base unchecked", 1, 1, L, PS, 1, 0, 0, 2'b00, mk(8'hCF, 64'd1));
    apply("R12 giga bit9",      1, 1, L, PS, 1, 0, 0, 2'b11, mk(8'hCF, 64'd1 << 9));
    apply("R12 giga bit18",     1, 1, L, PS, 1, 0, 0, 2'b11, mk(8'hCF, 64'd1 << 18));
    apply("R12 type 10",        1, 1, L, PS, 1, 0, 0, 2'b10, mk(8'hCF, 0));
    apply("R13 kind 11 fault",  1, 1, ST2, PS, 1, 0, 0, 2'b00, mk(8'h4F, 0));
    apply("R13 kind 11 clean",  1, 1, ST2, PS, 1, 0, 0, 2'b00, mk(8'hCF, 0));
    apply("R2 back to idle",    0, 0, L, PS, 1, 0, 0, 2'b00, mk(8'h00, 0));

    repeat (3) @(posedge clk);
    #2;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R2 scoreboard: actual=%0d pending expected=0", sb.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule